// File: doc/BRIEF.md
# Counter CSR access trap classifier

This block sits beside the CSR read path of a core that has a hypervisor extension. Each time the core attempts to read a user-level counter CSR, or attempts a hypervisor load, store or fence, the block decides the outcome. The attempt may proceed, it may raise an illegal-instruction exception, or it may raise a virtual-instruction exception. The decision uses the current privilege level, the virtualization bit, the XLEN mode and three 32-bit counter-enable words: one each from the machine, hypervisor and supervisor levels.

A request is presented with a one-cycle valid strobe. The verdict is captured in a register on that clock edge. It appears as three flags, exactly one of which is set. The flags keep their value until the next strobe. Between strobes the inputs may change freely.

The distinguishing rule concerns virtual user mode. A counter that the machine level permits but that is switched off by the supervisor enable word, the hypervisor enable word, or both, produces a virtual-instruction trap and not an illegal-instruction trap.

Top module: `ctr_trap_classifier`

## Requirements
- R1: With privilege encoding 3 (machine), every access to an accepted counter address gives allow, whatever the enable words and the virtualization bit hold.
- R2: Below machine level (privilege encodings 0 = user, 1 = supervisor), an accepted counter access whose machine enable bit is 0 gives illegal, whatever the virtualization bit is.
- R3: In supervisor mode with virt=0, a counter access gives allow exactly when the machine enable bit is 1; the hypervisor and supervisor enable bits have no effect.
- R4: In user mode with virt=0 and the machine enable bit at 1, a counter access gives allow when the supervisor enable bit is 1 and illegal when it is 0.
- R5: In supervisor mode with virt=1 and the machine enable bit at 1, a counter access gives allow when the hypervisor enable bit is 1 and virtual when it is 0; the supervisor enable bit has no effect.
- R6: In user mode with virt=1 and the machine enable bit at 1, a counter access gives allow when both the hypervisor and supervisor enable bits are 1, and virtual when either of them is 0.
- R7: The counter index is address bits [4:0]. Low-half counters occupy 0xC00 to 0xC1F and high-half counters occupy 0xC80 to 0xC9F. When xlen32=1, high-half counters follow R1 to R6 exactly as low-half counters do, using the same index.
- R8: A high-half address with xlen32=0 gives illegal in every mode.
- R9: With hyp_insn=1, the address is ignored and the outcome is as follows. Machine mode gives allow. Supervisor mode gives allow with virt=0 and virtual with virt=1. User mode gives illegal with virt=0 and virtual with virt=1.
- R10: With hyp_insn=0, an address outside both counter ranges gives illegal. Privilege encoding 2 gives illegal for every request.
- R11: The verdict appears one clock after the edge that samples req_valid=1. Exactly one of res_allow, res_illegal and res_virtual is then 1. It stays unchanged through cycles with req_valid=0.
- R12: While rst_n is low, all three result flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Strobe: classify the request on this edge |
| priv | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Virtualization bit |
| xlen32 | input | 1 | 1 when running with 32-bit XLEN |
| csr_addr | input | 12 | CSR address of the counter access |
| hyp_insn | input | 1 | Request is a hypervisor load/store/fence |
| m_cnt_en | input | 32 | Machine counter-enable word |
| h_cnt_en | input | 32 | Hypervisor counter-enable word |
| s_cnt_en | input | 32 | Supervisor counter-enable word |
| res_allow | output | 1 | Access may proceed |
| res_illegal | output | 1 | Raise illegal-instruction exception |
| res_virtual | output | 1 | Raise virtual-instruction exception |

## Verification
The bench builds the block with its default parameters. These give a 12-bit address, 32 counters, and range bases 0xC00 and 0xC80. Every counter index in both halves is therefore reachable, as are the addresses just beyond the low range and well outside both ranges. For each index, the bench sweeps all eight combinations of the selected machine, hypervisor and supervisor enable bits. It does this across all privilege encodings, both virt values and both XLEN settings, while the unselected enable bits vary, so that a wrong index shows up. Idle cycles with scrambled inputs then show that the verdict holds between strobes.

// File: rtl/ctr_trap_pkg.sv
package ctr_trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef struct packed {
    logic allow;
    logic illegal;
    logic virt;
  } verdict_t;

  localparam verdict_t VERDICT_ALLOW   = '{allow: 1'b1, illegal: 1'b0, virt: 1'b0};
  localparam verdict_t VERDICT_ILLEGAL = '{allow: 1'b0, illegal: 1'b1, virt: 1'b0};
  localparam verdict_t VERDICT_VIRTUAL = '{allow: 1'b0, illegal: 1'b0, virt: 1'b1};
  localparam verdict_t VERDICT_NONE    = '{allow: 1'b0, illegal: 1'b0, virt: 1'b0};
endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode #(
  parameter int          AW      = 12,
  parameter int          NCTR    = 32,
  parameter logic [11:0] LO_BASE = 12'hC00,
  parameter logic [11:0] HI_BASE = 12'hC80
) (
  input  logic [AW-1:0]           addr,
  input  logic                    xlen32,
  output logic                    ctr_ok,
  output logic                    hi_blocked,
  output logic [$clog2(NCTR)-1:0] idx
);
  localparam int IDX_W = $clog2(NCTR);

  logic in_lo;
  logic in_hi;

  always_comb begin
    in_lo      = (addr[AW-1:IDX_W] == LO_BASE[AW-1:IDX_W]);
    in_hi      = (addr[AW-1:IDX_W] == HI_BASE[AW-1:IDX_W]);
    idx        = addr[IDX_W-1:0];
    ctr_ok     = in_lo | (in_hi & xlen32);
    hi_blocked = in_hi & ~xlen32;
  end
endmodule

// File: rtl/ctr_trap_policy.sv
module ctr_trap_policy
  import ctr_trap_pkg::*;
(
  input  priv_e    priv,
  input  logic     virt,
  input  logic     hyp_insn,
  input  logic     ctr_ok,
  input  logic     m_bit,
  input  logic     h_bit,
  input  logic     s_bit,
  output verdict_t verdict
);
  always_comb begin
    verdict = VERDICT_ILLEGAL;
    if (priv == PRIV_RSV) begin
      verdict = VERDICT_ILLEGAL;
    end else if (hyp_insn) begin
      unique case (priv)
        PRIV_M:  verdict = VERDICT_ALLOW;
        PRIV_S:  verdict = virt ? VERDICT_VIRTUAL : VERDICT_ALLOW;
        default: verdict = virt ? VERDICT_VIRTUAL : VERDICT_ILLEGAL;
      endcase
    end else if (!ctr_ok) begin
      verdict = VERDICT_ILLEGAL;
    end else if (priv == PRIV_M) begin
      verdict = VERDICT_ALLOW;
    end else if (!m_bit) begin
      verdict = VERDICT_ILLEGAL;
    end else if (!virt) begin
      if (priv == PRIV_S) verdict = VERDICT_ALLOW;
      else                verdict = s_bit ? VERDICT_ALLOW : VERDICT_ILLEGAL;
    end else begin
      if (priv == PRIV_S) verdict = h_bit ? VERDICT_ALLOW : VERDICT_VIRTUAL;
      else                verdict = (h_bit & s_bit) ? VERDICT_ALLOW : VERDICT_VIRTUAL;
    end
  end
endmodule

// File: rtl/ctr_trap_classifier.sv
module ctr_trap_classifier
  import ctr_trap_pkg::*;
#(
  parameter int          AW      = 12,
  parameter int          NCTR    = 32,
  parameter logic [11:0] LO_BASE = 12'hC00,
  parameter logic [11:0] HI_BASE = 12'hC80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            xlen32,
  input  logic [AW-1:0]   csr_addr,
  input  logic            hyp_insn,
  input  logic [NCTR-1:0] m_cnt_en,
  input  logic [NCTR-1:0] h_cnt_en,
  input  logic [NCTR-1:0] s_cnt_en,
  output logic            res_allow,
  output logic            res_illegal,
  output logic            res_virtual
);
  localparam int IDX_W = $clog2(NCTR);

  logic             ctr_ok;
  logic             hi_blocked;
  logic [IDX_W-1:0] idx;
  priv_e            priv_q;
  verdict_t         verdict_d;
  verdict_t         verdict_q;
  verdict_t         verdict_nxt;

  assign priv_q = priv_e'(priv);

  ctr_addr_decode #(
    .AW(AW), .NCTR(NCTR), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) i_decode (
    .addr       (csr_addr),
    .xlen32     (xlen32),
    .ctr_ok     (ctr_ok),
    .hi_blocked (hi_blocked),
    .idx        (idx)
  );

  ctr_trap_policy i_policy (
    .priv     (priv_q),
    .virt     (virt),
    .hyp_insn (hyp_insn),
    .ctr_ok   (ctr_ok),
    .m_bit    (m_cnt_en[idx]),
    .h_bit    (h_cnt_en[idx]),
    .s_bit    (s_cnt_en[idx]),
    .verdict  (verdict_d)
  );

  always_comb begin
    verdict_nxt = verdict_q;
    if (req_valid) verdict_nxt = verdict_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verdict_q <= VERDICT_NONE;
    else        verdict_q <= verdict_nxt;
  end

  assign res_allow   = verdict_q.allow;
  assign res_illegal = verdict_q.illegal;
  assign res_virtual = verdict_q.virt;

  // R11
  one_hot_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $onehot({res_allow, res_illegal, res_virtual}));

  // R11
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable({res_allow, res_illegal, res_virtual}));

  // R1
  machine_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hyp_insn && priv == 2'd3 && ctr_ok) |=> res_allow);

  // R2
  machine_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hyp_insn && priv[1] == 1'b0 && ctr_ok && !m_cnt_en[idx]) |=> res_illegal);

  // R8
  high_half_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hyp_insn && hi_blocked) |=> res_illegal);

  // R9
  hyp_virtual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hyp_insn && virt && priv[1] == 1'b0) |=> res_virtual);
endmodule

// File: tb/test_ctr_trap_classifier.sv
module test_ctr_trap_classifier;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  priv;
  logic        virt;
  logic        xlen32;
  logic [11:0] csr_addr;
  logic        hyp_insn;
  logic [31:0] m_cnt_en, h_cnt_en, s_cnt_en;
  logic        res_allow, res_illegal, res_virtual;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_res;
  string      exp_tag;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_trap_classifier i_ctr_trap_classifier (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .priv(priv), .virt(virt),
    .xlen32(xlen32), .csr_addr(csr_addr), .hyp_insn(hyp_insn),
    .m_cnt_en(m_cnt_en), .h_cnt_en(h_cnt_en), .s_cnt_en(s_cnt_en),
    .res_allow(res_allow), .res_illegal(res_illegal), .res_virtual(res_virtual)
  );

  localparam logic [2:0] ALW = 3'b100;
  localparam logic [2:0] ILL = 3'b010;
  localparam logic [2:0] VRT = 3'b001;

  function automatic logic [2:0] model(int pv, bit v, bit x32, int addr, bit hyp,
                                       logic [31:0] m, logic [31:0] h, logic [31:0] s);
    int  k  = addr % 32;
    bit  lo = (addr >= 'hC00) && (addr <= 'hC1F);
    bit  hi = (addr >= 'hC80) && (addr <= 'hC9F);
    if (pv == 2) return ILL;
    if (hyp) begin
      if (pv == 3) return ALW;
      if (v) return VRT;
      return (pv == 1) ? ALW : ILL;
    end
    if (!lo && !hi) return ILL;
    if (hi && !x32) return ILL;
    if (pv == 3) return ALW;
    if (!m[k]) return ILL;
    if (!v) begin
      if (pv == 1) return ALW;
      return s[k] ? ALW : ILL;
    end
    if (pv == 1) return h[k] ? ALW : VRT;
    return (h[k] && s[k]) ? ALW : VRT;
  endfunction

  function automatic string tag_of(int pv, bit v, bit x32, int addr, bit hyp, bit mb);
    bit lo = (addr >= 'hC00) && (addr <= 'hC1F);
    bit hi = (addr >= 'hC80) && (addr <= 'hC9F);
    if (hyp) return "R9";
    if (pv == 2 || (!lo && !hi)) return "R10";
    if (hi && !x32) return "R8";
    if (hi) return "R7";
    if (pv == 3) return "R1";
    if (!mb) return "R2";
    if (pv == 1) return v ? "R5" : "R3";
    return v ? "R6" : "R4";
  endfunction

  always @(posedge clk) begin
    if (rst_n && req_valid) begin
      exp_res <= model(int'(priv), virt, xlen32, int'(csr_addr), hyp_insn,
                       m_cnt_en, h_cnt_en, s_cnt_en);
      exp_tag <= tag_of(int'(priv), virt, xlen32, int'(csr_addr), hyp_insn,
                        m_cnt_en[csr_addr[4:0]]);
    end else if (rst_n) begin
      exp_tag <= "R11";
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if ({res_allow, res_illegal, res_virtual} !== 3'b000) begin
        errors++;
        $display("FAIL R12 got %b exp 000", {res_allow, res_illegal, res_virtual});
      end
    end else if (exp_tag != "") begin
      checks++;
      if ({res_allow, res_illegal, res_virtual} !== exp_res) begin
        errors++;
        $display("FAIL %s got %b exp %b (priv %0d virt %0d x32 %0d addr %h hyp %0d)",
                 exp_tag, {res_allow, res_illegal, res_virtual}, exp_res,
                 priv, virt, xlen32, csr_addr, hyp_insn);
      end
    end
  end

  task automatic issue(int pv, bit v, bit x32, int addr, bit hyp,
                       logic [31:0] m, logic [31:0] h, logic [31:0] s);
    @(negedge clk);
    priv = pv[1:0]; virt = v; xlen32 = x32; csr_addr = addr[11:0];
    hyp_insn = hyp; m_cnt_en = m; h_cnt_en = h; s_cnt_en = s;
    req_valid = 1'b1;
  endtask

  initial begin
    int step = 0;
    exp_res = 3'b000; exp_tag = "";
    rst_n = 1'b0; req_valid = 1'b0; priv = 2'd0; virt = 1'b0; xlen32 = 1'b0;
    csr_addr = 12'h000; hyp_insn = 1'b0;
    m_cnt_en = '0; h_cnt_en = '0; s_cnt_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int pv = 0; pv < 4; pv++)
      for (int v = 0; v < 2; v++)
        for (int x = 0; x < 2; x++)
          for (int a = 0; a < 66; a++) begin
            int addr = (a < 32) ? ('hC00 + a) : (a < 64) ? ('hC80 + a - 32)
                     : (a == 64) ? 'hC20 : 'hB03;
            for (int c = 0; c < 8; c++) begin
              logic [31:0] bg = 32'h5A3C_96E1 ^ (32'(step) * 32'h0101_0101);
              logic [31:0] m = bg, h = ~bg, s = {bg[15:0], bg[31:16]};
              m[addr % 32] = c[2]; h[addr % 32] = c[1]; s[addr % 32] = c[0];
              issue(pv, v[0], x[0], addr, 1'b0, m, h, s);
              step++;
            end
          end

    for (int pv = 0; pv < 4; pv++)
      for (int v = 0; v < 2; v++)
        for (int r = 0; r < 3; r++)
          issue(pv, v[0], r[0], 'hC00 + r * 40, 1'b1, 32'h0, 32'h0, 32'h0);

    for (int r = 0; r < 4; r++) begin
      issue(r % 2, 1'b1, 1'b1, 'hC05 + r, 1'b0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
      for (int q = 0; q < 5; q++) begin
        @(negedge clk);
        req_valid = 1'b0;
        priv = 2'(q); virt = q[0]; csr_addr = 12'hC80 + 12'(q);
        m_cnt_en = ~m_cnt_en; h_cnt_en = ~h_cnt_en; hyp_insn = q[1];
      end
    end

    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog got timeout exp completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule